// File: doc/BRIEF.md
# Per-Core Countdown Timer with Vector Entry

This block is a per-core countdown timer. A bus clock passes through a programmable prescaler, and each prescaled tick decrements a counter of up to 32 bits. Software reaches the block through a single-cycle 32-bit register port that holds four registers: a prescale selector, a vector entry, a start value and a live count. Writing the start value loads the counter and starts the countdown.

When the count expires, the block emits a one-cycle interrupt request and places the programmed 8-bit vector beside it, unless the vector entry is masked. After expiry the timer either rests at zero (one-shot) or reloads the start value and runs again (periodic). Routing the request to a core is left to logic outside this block.

Register addresses on `bus_addr`: 0 is the prescale selector, 1 is the vector entry, 2 is the start value, and 3 is the live count. Reads are combinational from `bus_addr`. Writes take effect on the rising clock edge while `bus_wr_en` is high.

Top module: `core_countdown_timer`

## Requirements
- R1: After reset the live count and the start value read 0, the vector entry reads 0x0001_0000 (masked, one-shot, vector 0), the prescale selector reads 0, and `irq_pulse` is low.
- R2: The prescale selector keeps and returns all 32 written bits. Only the code {bit3,bit1,bit0} selects the ratio: 000=2, 001=4, 010=8, 011=16, 100=32, 101=64, 110=128, 111=1.
- R3: The vector entry places the vector in bits 7:0, the mask in bit 16 (1 = suppress) and periodic mode in bit 17 (1 = periodic). All other bits are discarded and read 0.
- R4: A write of N to the start value sets the live count to N at that edge and restarts the prescaler. With ratio r, the count then drops by one at edges r, 2r, 3r and so on after the load edge.
- R5: In one-shot mode the count goes from 1 to 0 at edge N*r and stays at 0. `irq_pulse` is high for exactly the one cycle that follows that edge.
- R6: In periodic mode the count goes from 1 straight back to N, and a pulse follows every N*r cycles.
- R7: With the mask bit set, expiry raises no pulse, while the count still runs down and stops or reloads as usual.
- R8: Writing a start value of 0 sets the count to 0 and stops the timer with no pulse, even while a countdown is running.
- R9: The start value reads back as written, and a write to the live count address changes nothing.
- R10: During the pulse, `irq_vector` equals the vector bits the entry held at the expiring edge. It keeps that value until the next delivered pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the last delivered request |

## Verification
The properties are checked on every cycle. They cover the following: a pulse never follows a masked entry; one-shot expiry leaves the count at zero; the count only holds, steps down by one or reloads; a zero start value silences the timer; and the delivered vector matches the entry. The scenarios are needed for the rest. They alone show that expiry lands on the exact cycle N*r for each prescale code, that periodic pulses keep their spacing, that register fields read back as specified, and that no request is ever missing or left over, which the scoreboard detects by comparing pulse cycles and vectors.

// File: rtl/timer_pkg.sv
package timer_pkg;
   localparam int TMR_DATA_W     = 32;
   localparam int TMR_VEC_W      = 8;
   localparam int LVT_MASK_POS   = 16;
   localparam int LVT_PERIOD_POS = 17;
   localparam int DIV_CODES      = 8;

   typedef enum logic [1:0] {
      REG_PRESCALE = 2'd0,
      REG_ENTRY    = 2'd1,
      REG_START    = 2'd2,
      REG_LIVE     = 2'd3
   } tmr_reg_e;

   typedef struct packed {
      logic                 periodic;
      logic                 mask;
      logic [TMR_VEC_W-1:0] vector;
   } tmr_entry_t;

   function automatic logic [2:0] div_code(input logic [3:0] sel);
      return {sel[3], sel[1:0]};
   endfunction
endpackage

// File: rtl/timer_prescale.sv
module timer_prescale
   import timer_pkg::*;
#(
   parameter int PRESCALE_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [2:0] code,
   output logic       tick
);
   localparam int LAST_CODE = DIV_CODES - 1;

   logic [PRESCALE_W-1:0] pcnt;
   logic [PRESCALE_W-1:0] low_mask [DIV_CODES];

   // Each code selects a low-bit mask; code 7 bypasses the divider.
   generate
      for (genvar g = 0; g < DIV_CODES; g++) begin : g_mask
         if (g == LAST_CODE) begin : g_bypass
            assign low_mask[g] = '0;
         end else begin : g_pow2
            assign low_mask[g] = PRESCALE_W'((1 << (g + 1)) - 1);
         end
      end
   endgenerate

   assign tick = (pcnt & low_mask[code]) == low_mask[code];

   always_ff @(posedge clk) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else              pcnt <= pcnt + 1'b1;
   end
endmodule

// File: rtl/timer_downcount.sv
module timer_downcount #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] count,
   output logic             expire,
   output logic             reload
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // A load on the same edge overrides expiry.
   assign expire = tick && !load && (count == ONE);
   assign reload = expire && periodic;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (tick && count != '0) begin
         if (reload) count <= load_val;
         else        count <= count - ONE;
      end
   end
endmodule

// File: rtl/timer_regs.sv
module timer_regs
   import timer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            addr,
   input  logic [TMR_DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]      live_count,
   output logic [TMR_DATA_W-1:0] prescale_q,
   output tmr_entry_t            entry_q,
   output logic [CNT_W-1:0]      start_q,
   output logic                  load_strobe,
   output logic [TMR_DATA_W-1:0] rdata
);
   tmr_reg_e sel;
   logic [TMR_DATA_W-1:0] entry_word;

   assign sel         = tmr_reg_e'(addr);
   assign load_strobe = wr_en && (sel == REG_START);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prescale_q       <= '0;
         entry_q.vector   <= '0;
         entry_q.mask     <= 1'b1;
         entry_q.periodic <= 1'b0;
         start_q          <= '0;
      end else if (wr_en) begin
         case (sel)
            REG_PRESCALE: prescale_q <= wdata;
            REG_ENTRY: begin
               entry_q.vector   <= wdata[TMR_VEC_W-1:0];
               entry_q.mask     <= wdata[LVT_MASK_POS];
               entry_q.periodic <= wdata[LVT_PERIOD_POS];
            end
            REG_START:  start_q <= wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      entry_word                    = '0;
      entry_word[TMR_VEC_W-1:0]     = entry_q.vector;
      entry_word[LVT_MASK_POS]      = entry_q.mask;
      entry_word[LVT_PERIOD_POS]    = entry_q.periodic;
      case (sel)
         REG_PRESCALE: rdata = prescale_q;
         REG_ENTRY:    rdata = entry_word;
         REG_START:    rdata = TMR_DATA_W'(start_q);
         default:      rdata = TMR_DATA_W'(live_count);
      endcase
   end
endmodule

// File: rtl/timer_irq_out.sv
module timer_irq_out
   import timer_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 expire,
   input  tmr_entry_t           entry,
   output logic                 irq_pulse,
   output logic [TMR_VEC_W-1:0] irq_vector
);
   logic deliver;
   assign deliver = expire && !entry.mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_pulse  <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_pulse <= deliver;
         if (deliver) irq_vector <= entry.vector;
      end
   end
endmodule

// File: rtl/core_countdown_timer.sv
module core_countdown_timer
   import timer_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int PRESCALE_W = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr_en,
   input  logic [1:0]            bus_addr,
   input  logic [TMR_DATA_W-1:0] bus_wdata,
   output logic [TMR_DATA_W-1:0] bus_rdata,
   output logic                  irq_pulse,
   output logic [TMR_VEC_W-1:0]  irq_vector
);
   generate
      if (CNT_W < 2 || CNT_W > TMR_DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and the data width");
      end
      if (PRESCALE_W < DIV_CODES - 1) begin : g_bad_pre
         $error("PRESCALE_W too small for the largest prescale ratio");
      end
   endgenerate

   logic [TMR_DATA_W-1:0] prescale_q;
   tmr_entry_t            entry_q;
   logic [CNT_W-1:0]      start_q;
   logic [CNT_W-1:0]      live_count;
   logic                  load_strobe;
   logic                  tick;
   logic                  expire;
   logic                  reload;

   timer_regs #(.CNT_W(CNT_W)) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (bus_wr_en),
      .addr        (bus_addr),
      .wdata       (bus_wdata),
      .live_count  (live_count),
      .prescale_q  (prescale_q),
      .entry_q     (entry_q),
      .start_q     (start_q),
      .load_strobe (load_strobe),
      .rdata       (bus_rdata)
   );

   timer_prescale #(.PRESCALE_W(PRESCALE_W)) pre_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load_strobe),
      .code    (div_code(prescale_q[3:0])),
      .tick    (tick)
   );

   // Load value is the bus word on a start write, otherwise the stored start.
   timer_downcount #(.CNT_W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_strobe),
      .load_val (load_strobe ? bus_wdata[CNT_W-1:0] : start_q),
      .tick     (tick),
      .periodic (entry_q.periodic),
      .count    (live_count),
      .expire   (expire),
      .reload   (reload)
   );

   timer_irq_out irq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire     (expire),
      .entry      (entry_q),
      .irq_pulse  (irq_pulse),
      .irq_vector (irq_vector)
   );
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load,
   input logic [CNT_W-1:0] load_word,
   input logic [CNT_W-1:0] start_val,
   input logic [CNT_W-1:0] count,
   input logic             mask,
   input logic             periodic,
   input logic [7:0]       vector,
   input logic             irq_pulse,
   input logic [7:0]       irq_vector
);
   assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> !$past(mask));

   assert_oneshot_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pulse && !$past(periodic)) |-> count == '0);

   assert_zero_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !load) |=> count == '0);

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0 && !load) |=>
         (count == $past(count) || count == $past(count) - 1'b1 ||
          count == $past(start_val)));

   assert_zero_start_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_word == '0) |=> (count == '0 && !irq_pulse));

   assert_pulse_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> irq_vector == $past(vector));
endmodule

bind core_countdown_timer timer_checker #(.CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .load       (load_strobe),
   .load_word  (bus_wdata[CNT_W-1:0]),
   .start_val  (start_q),
   .count      (live_count),
   .mask       (entry_q.mask),
   .periodic   (entry_q.periodic),
   .vector     (entry_q.vector),
   .irq_pulse  (irq_pulse),
   .irq_vector (irq_vector)
);

// File: tb/core_countdown_timer_tb.sv
`timescale 1ns/1ps
module core_countdown_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_pulse;
   logic [7:0]  irq_vector;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   typedef struct {
      int         at;
      logic [7:0] vec;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   core_countdown_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_pulse(irq_pulse), .irq_vector(irq_vector)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // Returns at the negedge after the write edge; cyc then equals the load edge count.
   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic expect_irq(input int at, input logic [7:0] vec, input string tag);
      exp_t e;
      e.at = at; e.vec = vec; e.tag = tag;
      sb_q.push_back(e);
   endtask

   function automatic logic [31:0] oneshot_count(input int l, input int n, input int r, input int c);
      if (c - l >= n * r) return 0;
      return 32'(n - (c - l) / r);
   endfunction

   task automatic check_live(input string tag, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(2'd3, d);
      check(tag, d, exp);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && irq_pulse) begin
         checks++;
         if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL R7/R8 unexpected irq at cycle %0d vector=0x%02h expected none", cyc, irq_vector);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.at != cyc || e.vec !== irq_vector) begin
               errors++;
               $display("FAIL %s irq cycle=%0d vector=0x%02h expected cycle=%0d vector=0x%02h",
                        e.tag, cyc, irq_vector, e.at, e.vec);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int l;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(2'd3, d); check("R1 live", d, 0);
      bus_read(2'd2, d); check("R1 start", d, 0);
      bus_read(2'd1, d); check("R1 entry", d, 32'h0001_0000);
      bus_read(2'd0, d); check("R1 prescale", d, 0);
      check("R1 irq", {31'd0, irq_pulse}, 0);

      // R2 / R3 field read-back
      bus_write(2'd0, 32'hABCD_0003);
      bus_read(2'd0, d); check("R2 prescale readback", d, 32'hABCD_0003);
      bus_write(2'd1, 32'hFFFF_FF41);
      bus_read(2'd1, d); check("R3 entry fields", d, 32'h0003_0041);
      bus_write(2'd1, 32'h0000_0041);

      // One-shot, ratio 16 (code 011), N=3
      bus_write(2'd2, 32'd3); l = cyc;
      expect_irq(l + 48, 8'h41, "R5 oneshot r16");
      bus_read(2'd2, d); check("R9 start readback", d, 3);
      wait_until(l + 15); check_live("R4 before first tick", 3);
      wait_until(l + 16); check_live("R4 first tick", 2);
      bus_write(2'd3, 32'h55);
      wait_until(l + 24); check_live("R9 live write ignored", oneshot_count(l, 3, 16, cyc));
      wait_until(l + 60); check_live("R5 rests at zero", 0);
      check("R10 vector held", {24'd0, irq_vector}, 32'h41);

      // One-shot ratio 1 (code 111)
      bus_write(2'd0, 32'h0000_000B);
      bus_write(2'd2, 32'd5); l = cyc;
      expect_irq(l + 5, 8'h41, "R2 ratio1");
      wait_until(l + 2); check_live("R2 ratio1 count", 3);
      wait_until(l + 10);

      // One-shot ratio 128 (code 110)
      bus_write(2'd0, 32'h0000_000A);
      bus_write(2'd2, 32'd2); l = cyc;
      expect_irq(l + 256, 8'h41, "R2 ratio128");
      wait_until(l + 130); check_live("R2 ratio128 count", 1);
      wait_until(l + 262);

      // Periodic, ratio 2 (code 000), N=4, vector 0x77
      bus_write(2'd0, 32'h0000_0000);
      bus_write(2'd1, 32'h0002_0077);
      bus_write(2'd2, 32'd4); l = cyc;
      expect_irq(l + 8,  8'h77, "R6 period 1");
      expect_irq(l + 16, 8'h77, "R6 period 2");
      expect_irq(l + 24, 8'h77, "R6 period 3");
      wait_until(l + 9); check_live("R6 reload to start", 4);
      wait_until(l + 25);
      bus_write(2'd2, 32'd0);
      check_live("R8 stopped", 0);
      wait_until(l + 60); check_live("R8 still stopped", 0);

      // Masked one-shot, ratio 1
      bus_write(2'd0, 32'h0000_000B);
      bus_write(2'd1, 32'h0001_0042);
      bus_write(2'd2, 32'd6); l = cyc;
      wait_until(l + 3); check_live("R7 counts while masked", 3);
      wait_until(l + 10); check_live("R7 masked expiry", 0);
      check("R10 vector unchanged by masked expiry", {24'd0, irq_vector}, 32'h77);

      // Zero start stops a running count
      bus_write(2'd1, 32'h0000_0042);
      bus_write(2'd2, 32'd50); l = cyc;
      wait_until(l + 5);
      bus_write(2'd2, 32'd0);
      check_live("R8 zero write", 0);
      wait_until(l + 80); check_live("R8 no restart", 0);

      checks++;
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL R5/R6 missing irq count=%0d expected=0", sb_q.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule